// File: doc/BRIEF.md
# Fractional Oversampling Tick Generator

This block derives the sample-enable pulse for an oversampling serial receiver from a fast system clock whose frequency is not a whole multiple of the sample rate. With a 100 MHz clock, 115200 baud and eight samples per bit, the ideal spacing is about 108.51 clocks per sample. A single fixed divider would let the sampling point slide further from the bit centre on every bit of a frame. This block avoids that by using two whole-number periods in turn: 108 clocks for every sample of an even-indexed bit and 109 clocks for every sample of an odd-indexed bit. Over each pair of bits the average then matches the ideal ratio to within a fraction of a clock.

Each tick is a single-cycle pulse. The block counts the ticks of each bit. On the last tick of a bit it raises a bit-boundary strobe in the same cycle as that tick, and it flips the even/odd flag that selects the next period. A resync pulse, typically driven by start-bit edge detection, restarts everything at bit index 0. The first bit after reset or resync is always treated as even. Both periods and the sample count per bit are parameters.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst` is high, `tick` and `bit_strobe` are low. The first `tick` after reset appears in the cycle 108 (DIV_EVEN) clocks after the last reset cycle.
- R2: `tick` is never high in two consecutive cycles.
- R3: During an even-indexed bit the spacing between consecutive ticks is 108 (DIV_EVEN) clocks. Bit index 0 is the first bit after reset or resync, and ticks 0 to 7 after that point belong to it.
- R4: During an odd-indexed bit the spacing between consecutive ticks is 109 (DIV_ODD) clocks. After each group of 8 (SAMPLES_PER_BIT) ticks the bit parity flips.
- R5: `bit_strobe` is high exactly in the cycle of the 8th tick of each bit, that is, ticks 7, 15, 23 and so on counted from 0, always together with `tick`. It is low in every other cycle.
- R6: In a cycle with `resync` high, `tick` and `bit_strobe` are low. This holds even when that cycle would otherwise carry a tick or a strobe. The next tick appears 108 clocks after the resync cycle, and bit indexing restarts at 0.
- R7: Within one run between resyncs, any 16 consecutive tick-to-tick intervals total exactly 1736 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| resync | input | 1 | Synchronous restart of the sample phase and bit index |
| tick | output | 1 | One-cycle sample enable |
| bit_strobe | output | 1 | One-cycle marker on the last sample of each bit |

## Verification
Resync can land in the same cycle as a tick or as a bit-boundary strobe, and resync must win. The bench predicts those cycles from its own period model. It drives resync directly onto a predicted strobe cycle and onto a predicted plain tick cycle, and it also fires resync at random moments. In each case it expects both outputs low in the resync cycle, the next tick exactly 108 clocks later, and the following strobe after a fresh group of eight ticks.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

  function automatic int unsigned ftg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned ftg_width(input int unsigned v);
    int unsigned w;
    w = $clog2(v);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/ftg_period_ctr.sv
module ftg_period_ctr #(
  parameter int unsigned DIV_EVEN = 108,
  parameter int unsigned DIV_ODD  = 109
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sel_odd,
  output logic at_end
);
  import ftg_pkg::*;

  localparam int unsigned DIV_MAX = ftg_max(DIV_EVEN, DIV_ODD);
  localparam int unsigned CNT_W   = ftg_width(DIV_MAX);
  localparam logic [CNT_W-1:0] LIM_EVEN = CNT_W'(DIV_EVEN - 1);
  localparam logic [CNT_W-1:0] LIM_ODD  = CNT_W'(DIV_ODD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = sel_odd ? LIM_ODD : LIM_EVEN;
  assign at_end = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ftg_sample_ctr.sv
module ftg_sample_ctr #(
  parameter int unsigned SAMPLES_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic last
);
  import ftg_pkg::*;

  localparam int unsigned SAMP_W = ftg_width(SAMPLES_PER_BIT);
  localparam logic [SAMP_W-1:0] LAST_IDX = SAMP_W'(SAMPLES_PER_BIT - 1);

  logic [SAMP_W-1:0] idx_q;

  assign last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/ftg_parity.sv
module ftg_parity (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic flip,
  output logic odd
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      odd <= 1'b0;
    end else if (flip) begin
      odd <= ~odd;
    end
  end

endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen #(
  parameter int unsigned DIV_EVEN        = 108,
  parameter int unsigned DIV_ODD         = 109,
  parameter int unsigned SAMPLES_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic resync,
  output logic tick,
  output logic bit_strobe
);

  logic odd_q;
  logic period_end;
  logic sample_last;

  ftg_period_ctr #(
    .DIV_EVEN (DIV_EVEN),
    .DIV_ODD  (DIV_ODD)
  ) u_period (
    .clk     (clk),
    .rst     (rst),
    .clr     (resync),
    .sel_odd (odd_q),
    .at_end  (period_end)
  );

  assign tick       = period_end & ~resync & ~rst;
  assign bit_strobe = tick & sample_last;

  ftg_sample_ctr #(
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT)
  ) u_samples (
    .clk  (clk),
    .rst  (rst),
    .clr  (resync),
    .adv  (tick),
    .last (sample_last)
  );

  ftg_parity u_parity (
    .clk  (clk),
    .rst  (rst),
    .clr  (resync),
    .flip (bit_strobe),
    .odd  (odd_q)
  );

endmodule

// File: rtl/frac_tick_gen_chk.sv
module frac_tick_gen_chk #(
  parameter int unsigned DIV_EVEN        = 108,
  parameter int unsigned DIV_ODD         = 109,
  parameter int unsigned SAMPLES_PER_BIT = 8
) (
  input logic clk,
  input logic rst,
  input logic resync,
  input logic tick,
  input logic bit_strobe,
  input logic odd
);

  logic [15:0] gap_q;
  logic [15:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || resync || tick) begin
      gap_q <= 16'd1;
    end else begin
      gap_q <= gap_q + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      seen_q <= 16'd0;
    end else if (tick) begin
      seen_q <= bit_strobe ? 16'd0 : seen_q + 16'd1;
    end
  end

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    rst |-> (!tick && !bit_strobe));

  // R2
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3 and R4
  a_r3_period: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == (odd ? 16'(DIV_ODD) : 16'(DIV_EVEN))));

  a_r4_parity_flips: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |=> (odd != $past(odd)));

  // R5
  a_r5_strobe_on_last: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> (tick && seen_q == 16'(SAMPLES_PER_BIT - 1)));

  a_r5_last_gives_strobe: assert property (@(posedge clk) disable iff (rst)
    (tick && seen_q == 16'(SAMPLES_PER_BIT - 1)) |-> bit_strobe);

  // R6
  a_r6_resync_quiet: assert property (@(posedge clk) disable iff (rst)
    resync |-> (!tick && !bit_strobe));

  a_r6_resync_even: assert property (@(posedge clk) disable iff (rst)
    resync |=> !odd);

endmodule

bind frac_tick_gen frac_tick_gen_chk #(
  .DIV_EVEN        (DIV_EVEN),
  .DIV_ODD         (DIV_ODD),
  .SAMPLES_PER_BIT (SAMPLES_PER_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .resync     (resync),
  .tick       (tick),
  .bit_strobe (bit_strobe),
  .odd        (odd_q)
);

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;

  localparam int EVEN_P  = 108;
  localparam int ODD_P   = 109;
  localparam int SPB     = 8;
  localparam int WIN_SUM = 1736;
  localparam int RUN_CYC = 70000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic resync = 1'b0;
  logic tick;
  logic bit_strobe;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frac_tick_gen u_frac_tick_gen (
    .clk        (clk),
    .rst        (rst),
    .resync     (resync),
    .tick       (tick),
    .bit_strobe (bit_strobe)
  );

  function automatic int exp_period(input int k);
    return (((k / SPB) % 2) == 0) ? EVEN_P : ODD_P;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int gap = 0;
  int k = 0;
  bit from_reset = 1'b1;
  int ring [16];
  int nwin = 0;
  int prev_tick = 0;
  int n_strobe_hits = 0;
  int n_tick_hits = 0;

  function automatic string tick_tag();
    if (k == 0) return from_reset ? "R1" : "R6";
    return (((k / SPB) % 2) == 0) ? "R3" : "R4";
  endfunction

  task automatic cycle(input bit r, input bit s);
    int sum;
    bit expt;
    @(negedge clk);
    rst = r;
    resync = s;
    #1;
    if (r) begin
      check("R1", int'(tick), 0);
      check("R1", int'(bit_strobe), 0);
      gap = 0; k = 0; nwin = 0; from_reset = 1'b1;
      prev_tick = 0;
      return;
    end
    gap++;
    expt = (gap == exp_period(k)) && !s;
    if (s) begin
      check("R6", int'(tick), 0);
      check("R6", int'(bit_strobe), 0);
    end else begin
      check(tick_tag(), int'(tick), int'(expt));
      check("R5", int'(bit_strobe), int'(expt && ((k % SPB) == SPB - 1)));
    end
    if (prev_tick == 1) check("R2", int'(tick), 0);
    prev_tick = int'(tick);
    if (s) begin
      gap = 0; k = 0; nwin = 0; from_reset = 1'b0;
    end else if (tick) begin
      ring[nwin % 16] = gap;
      nwin++;
      if (nwin >= 16) begin
        sum = 0;
        for (int i = 0; i < 16; i++) sum += ring[i];
        check("R7", sum, WIN_SUM);
      end
      gap = 0;
      k++;
    end
  endtask

  function automatic bit next_is_tick();
    return (gap + 1) == exp_period(k);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0);
    // directed: reset exit, several bit pairs
    for (int i = 0; i < 5000; i++) cycle(1'b0, 1'b0);
    // directed: resync on a predicted strobe cycle
    while (n_strobe_hits < 2) begin
      if (next_is_tick() && (k % SPB) == SPB - 1) begin
        cycle(1'b0, 1'b1);
        n_strobe_hits++;
      end else begin
        cycle(1'b0, 1'b0);
      end
    end
    // directed: resync on a predicted plain tick cycle
    while (n_tick_hits < 2) begin
      if (next_is_tick() && (k % SPB) == 3) begin
        cycle(1'b0, 1'b1);
        n_tick_hits++;
      end else begin
        cycle(1'b0, 1'b0);
      end
    end
    // directed: back-to-back resync then reset mid-run
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 3000; i++) cycle(1'b0, 1'b0);
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 2500; i++) cycle(1'b0, 1'b0);
    // random resync moments
    for (int i = 0; i < RUN_CYC; i++) begin
      cycle(1'b0, (($urandom % 4000) == 0));
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule